// File: doc/BRIEF.md
# System Register Access Permission Checker

This block judges whether one system-register access may proceed. A requester presents the five instruction-encoding fields, the access direction, the current exception level and a set of control bits: core halted, secure-debug lock, security state, a two-bit owner field, second-level hypervisor enabled, third level present, fine-grained trap enable, separate read and write fine-grained trap bits, a two-bit trace-buffer trap field and a priority option that the implementation chooses. Together with a request strobe, it returns exactly one verdict: permit, undefined, trap to EL2 or trap to EL3. It also returns a syndrome class for trap verdicts.

The rules form an ordered chain, and the first rule that fires decides the verdict. Debug-halt conditions take precedence over traps. The EL1 path has two extra hypervisor checks that the EL2 path skips. The block only decides. It neither performs the register access nor raises the exception. A request whose encoding differs from the configured one yields a no-match flag and no verdict.

Top module: `sysreg_perm_top`

## Requirements
- R1: A request matches only when op0=2'b11, op1=3'b000, crn=4'b1001, crm=4'b1011 and op2=3'b110, for either direction. Any other encoding raises `res_nomatch_o` with `res_outcome_o`=0 and `res_syndrome_o`=0.
- R2: A matching request from EL0 (`el_i`=0) gives undefined. One from EL3 (`el_i`=3) gives permit, whatever the control bits.
- R3: At EL1 or EL2, the first rule is undefined. It fires when halted, third level present, debug lock and priority option are all 1 and the owner field is wrong for the state. The field must be 2'b01 when `nonsecure_i`=0 and 2'b11 when `nonsecure_i`=1.
- R4: At EL1 only, the next rule is trap to EL2. It fires when the hypervisor is enabled, either the third level is absent or the fine-grained enable is 1, and the fine-grained bit for the direction is 1. Reads use `fgt_rd_i` and writes use `fgt_wr_i`.
- R5: At EL1 only, the next rule is trap to EL2. It fires when the hypervisor is enabled and bit 0 of `tbtrap_i` is 0.
- R6: At EL1 or EL2, the next rule applies when the third level is present and the owner field is wrong for the state. The verdict is undefined if halted and debug lock are both 1, and trap to EL3 otherwise.
- R7: `res_syndrome_o` is 6'h18 with either trap verdict and 0 with every other verdict.
- R8: Rules are applied strictly in the order R3, R4, R5, R6, and the earliest rule that fires wins. When none fires, the verdict is permit.
- R9: The verdict appears one clock after `req_valid_i`, together with a one-cycle `res_valid_o`. `res_outcome_o` is one-hot, with bit0 permit, bit1 undefined, bit2 trap to EL2 and bit3 trap to EL3.
- R10: During reset and in any cycle without a result, `res_valid_o`, `res_nomatch_o`, `res_outcome_o` and `res_syndrome_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| op0_i | input | 2 | Encoding field op0 |
| op1_i | input | 3 | Encoding field op1 |
| crn_i | input | 4 | Encoding field CRn |
| crm_i | input | 4 | Encoding field CRm |
| op2_i | input | 3 | Encoding field op2 |
| write_i | input | 1 | 1 = write, 0 = read |
| el_i | input | 2 | Current exception level |
| halted_i | input | 1 | Core in debug halt |
| dbg_lock_i | input | 1 | Secure debug disabled |
| nonsecure_i | input | 1 | Current security state is non-secure |
| owner_i | input | 2 | Owner field of the trace buffer |
| el2_en_i | input | 1 | Second-level hypervisor enabled |
| el3_present_i | input | 1 | Third exception level implemented |
| fgt_en_i | input | 1 | Fine-grained trap enable |
| fgt_rd_i | input | 1 | Fine-grained trap bit for reads |
| fgt_wr_i | input | 1 | Fine-grained trap bit for writes |
| tbtrap_i | input | 2 | Trace-buffer trap field (bit 0 used) |
| prio_opt_i | input | 1 | Debug-halt priority option |
| res_valid_o | output | 1 | Result strobe |
| res_nomatch_o | output | 1 | Encoding did not match |
| res_outcome_o | output | 4 | One-hot verdict |
| res_syndrome_o | output | 6 | Syndrome class |

## Verification
A wrong rule order or a swapped read/write trap bit shows up as a verdict bit in the wrong position in the cycle right after the triggering request. No state carries from one request to the next, so each fault is visible at once and never later. The bench sweeps every combination of level, direction and control bits against an arithmetic model, so every ordering conflict between the rules gets exercised. It also flips each encoding bit in turn to expose any decode fault.

// File: rtl/sysreg_perm_pkg.sv
package sysreg_perm_pkg;
  localparam int OUT_W = 4;
  localparam int SYN_W = 6;
  localparam int ENC_W = 16;

  localparam int BIT_PERMIT = 0;
  localparam int BIT_UNDEF  = 1;
  localparam int BIT_TRAP2  = 2;
  localparam int BIT_TRAP3  = 3;

  localparam logic [SYN_W-1:0] SYN_TRAP = 6'h18;
  localparam logic [1:0] OWN_SECURE    = 2'b01;
  localparam logic [1:0] OWN_NONSECURE = 2'b11;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} level_t;

  typedef struct packed {
    logic       halted;
    logic       dbg_lock;
    logic       nonsecure;
    logic [1:0] owner;
    logic       el2_en;
    logic       el3_present;
    logic       fgt_en;
    logic       fgt_rd;
    logic       fgt_wr;
    logic [1:0] tbtrap;
    logic       prio_opt;
  } ctrl_t;
endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match #(
  parameter int NF = 5,
  parameter int FW = 4,
  parameter logic [NF*FW-1:0] TARGET = '0,
  parameter logic [NF*FW-1:0] MASK   = '0
) (
  input  logic [NF*FW-1:0] fields_i,
  output logic             match_o
);
  logic [NF-1:0] field_hit;

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_field
      assign field_hit[g] = ((fields_i[g*FW +: FW] ^ TARGET[g*FW +: FW]) & MASK[g*FW +: FW]) == '0;
    end
  endgenerate

  assign match_o = &field_hit;
endmodule

// File: rtl/sysreg_rule_chain.sv
module sysreg_rule_chain
  import sysreg_perm_pkg::*;
(
  input  level_t             el_i,
  input  logic               write_i,
  input  ctrl_t              ctrl_i,
  output logic [OUT_W-1:0]   outcome_o,
  output logic [SYN_W-1:0]   syn_o
);
  logic owner_ok;
  logic halt_lock_rule;
  logic fgt_rule;
  logic tb_rule;
  logic owner_rule;
  logic fgt_bit;

  always_comb begin
    owner_ok       = ctrl_i.nonsecure ? (ctrl_i.owner == OWN_NONSECURE)
                                      : (ctrl_i.owner == OWN_SECURE);
    fgt_bit        = write_i ? ctrl_i.fgt_wr : ctrl_i.fgt_rd;
    halt_lock_rule = ctrl_i.halted & ctrl_i.el3_present & ctrl_i.dbg_lock &
                     ctrl_i.prio_opt & ~owner_ok;
    fgt_rule       = (el_i == LVL1) & ctrl_i.el2_en &
                     (~ctrl_i.el3_present | ctrl_i.fgt_en) & fgt_bit;
    tb_rule        = (el_i == LVL1) & ctrl_i.el2_en & ~ctrl_i.tbtrap[0];
    owner_rule     = ctrl_i.el3_present & ~owner_ok;
  end

  always_comb begin
    outcome_o = '0;
    unique case (el_i)
      LVL0: outcome_o[BIT_UNDEF] = 1'b1;
      LVL3: outcome_o[BIT_PERMIT] = 1'b1;
      default: begin
        if (halt_lock_rule)      outcome_o[BIT_UNDEF]  = 1'b1;
        else if (fgt_rule)       outcome_o[BIT_TRAP2]  = 1'b1;
        else if (tb_rule)        outcome_o[BIT_TRAP2]  = 1'b1;
        else if (owner_rule) begin
          if (ctrl_i.halted & ctrl_i.dbg_lock) outcome_o[BIT_UNDEF] = 1'b1;
          else                                 outcome_o[BIT_TRAP3] = 1'b1;
        end
        else                     outcome_o[BIT_PERMIT] = 1'b1;
      end
    endcase
    syn_o = (outcome_o[BIT_TRAP2] | outcome_o[BIT_TRAP3]) ? SYN_TRAP : '0;
  end
endmodule

// File: rtl/sysreg_result_reg.sv
module sysreg_result_reg
  import sysreg_perm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid_i,
  input  logic             match_i,
  input  logic [OUT_W-1:0] outcome_i,
  input  logic [SYN_W-1:0] syn_i,
  output logic             valid_o,
  output logic             nomatch_o,
  output logic [OUT_W-1:0] outcome_o,
  output logic [SYN_W-1:0] syn_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      nomatch_o <= 1'b0;
      outcome_o <= '0;
      syn_o     <= '0;
    end else begin
      valid_o   <= req_valid_i;
      nomatch_o <= req_valid_i & ~match_i;
      outcome_o <= (req_valid_i & match_i) ? outcome_i : '0;
      syn_o     <= (req_valid_i & match_i) ? syn_i : '0;
    end
  end

  // R9: a matched result carries exactly one verdict bit
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !nomatch_o) |-> ($countones(outcome_o) == 1));
  // R1: no verdict on a non-matching request
  a_r1_nomatch_clear: assert property (@(posedge clk) disable iff (rst)
    nomatch_o |-> (outcome_o == '0 && syn_o == '0));
  // R7: trap verdicts carry the trap syndrome, others none
  a_r7_syndrome: assert property (@(posedge clk) disable iff (rst)
    (outcome_o[BIT_TRAP2] || outcome_o[BIT_TRAP3]) == (syn_o == SYN_TRAP));
  // R10: idle cycles show nothing
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (!nomatch_o && outcome_o == '0));
endmodule

// File: rtl/sysreg_perm_top.sv
module sysreg_perm_top
  import sysreg_perm_pkg::*;
#(
  parameter logic [1:0] T_OP0 = 2'b11,
  parameter logic [2:0] T_OP1 = 3'b000,
  parameter logic [3:0] T_CRN = 4'b1001,
  parameter logic [3:0] T_CRM = 4'b1011,
  parameter logic [2:0] T_OP2 = 3'b110
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid_i,
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic       write_i,
  input  logic [1:0] el_i,
  input  logic       halted_i,
  input  logic       dbg_lock_i,
  input  logic       nonsecure_i,
  input  logic [1:0] owner_i,
  input  logic       el2_en_i,
  input  logic       el3_present_i,
  input  logic       fgt_en_i,
  input  logic       fgt_rd_i,
  input  logic       fgt_wr_i,
  input  logic [1:0] tbtrap_i,
  input  logic       prio_opt_i,
  output logic       res_valid_o,
  output logic       res_nomatch_o,
  output logic [3:0] res_outcome_o,
  output logic [5:0] res_syndrome_o
);
  localparam int NF = 5;
  localparam int FW = 4;
  localparam logic [NF*FW-1:0] TGT = {1'b0, T_OP2, T_CRM, T_CRN, 1'b0, T_OP1, 2'b00, T_OP0};
  localparam logic [NF*FW-1:0] MSK = {4'b0111, 4'b1111, 4'b1111, 4'b0111, 4'b0011};

  logic [NF*FW-1:0] fields;
  logic             match;
  ctrl_t            ctrl;
  logic [OUT_W-1:0] outcome_c;
  logic [SYN_W-1:0] syn_c;

  assign fields = {1'b0, op2_i, crm_i, crn_i, 1'b0, op1_i, 2'b00, op0_i};

  always_comb begin
    ctrl.halted      = halted_i;
    ctrl.dbg_lock    = dbg_lock_i;
    ctrl.nonsecure   = nonsecure_i;
    ctrl.owner       = owner_i;
    ctrl.el2_en      = el2_en_i;
    ctrl.el3_present = el3_present_i;
    ctrl.fgt_en      = fgt_en_i;
    ctrl.fgt_rd      = fgt_rd_i;
    ctrl.fgt_wr      = fgt_wr_i;
    ctrl.tbtrap      = tbtrap_i;
    ctrl.prio_opt    = prio_opt_i;
  end

  sysreg_enc_match #(.NF(NF), .FW(FW), .TARGET(TGT), .MASK(MSK)) u_match (
    .fields_i (fields),
    .match_o  (match)
  );

  sysreg_rule_chain u_chain (
    .el_i      (level_t'(el_i)),
    .write_i   (write_i),
    .ctrl_i    (ctrl),
    .outcome_o (outcome_c),
    .syn_o     (syn_c)
  );

  sysreg_result_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .match_i     (match),
    .outcome_i   (outcome_c),
    .syn_i       (syn_c),
    .valid_o     (res_valid_o),
    .nomatch_o   (res_nomatch_o),
    .outcome_o   (res_outcome_o),
    .syn_o       (res_syndrome_o)
  );

  // R9: result strobe exactly one cycle after the request
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> res_valid_o);
  // R2: matched EL0 request is undefined
  a_r2_el0_undef: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && match && el_i == 2'd0) |=> res_outcome_o[BIT_UNDEF]);
  // R2: matched EL3 request is permitted
  a_r2_el3_permit: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && match && el_i == 2'd3) |=> res_outcome_o[BIT_PERMIT]);
  // R4: an EL2 request never gets a hypervisor trap
  a_r4_no_trap2_at_el2: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && el_i == 2'd2) |=> !res_outcome_o[BIT_TRAP2]);
endmodule

// File: tb/tb_sysreg_perm_top.sv
module tb_sysreg_perm_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid_i = 1'b0;
  logic [1:0] op0_i = 2'b11;
  logic [2:0] op1_i = 3'b000;
  logic [3:0] crn_i = 4'b1001;
  logic [3:0] crm_i = 4'b1011;
  logic [2:0] op2_i = 3'b110;
  logic write_i = 0, halted_i = 0, dbg_lock_i = 0, nonsecure_i = 0;
  logic [1:0] el_i = 0, owner_i = 0, tbtrap_i = 0;
  logic el2_en_i = 0, el3_present_i = 0, fgt_en_i = 0, fgt_rd_i = 0, fgt_wr_i = 0, prio_opt_i = 0;
  logic res_valid_o, res_nomatch_o;
  logic [3:0] res_outcome_o;
  logic [5:0] res_syndrome_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysreg_perm_top dut (.*);

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (valid,nomatch,outcome,syn)", req, act, exp);
    end
  endtask

  // independent model: returns {outcome[3:0], syn[5:0]}
  function automatic logic [9:0] model(input int v);
    int el = v & 3;
    bit wr = v[2], hlt = v[3], lck = v[4], prio = v[5], ns = v[6];
    int own = (v >> 7) & 3;
    bit e2 = v[9], e3 = v[10], fen = v[11], frd = v[12], fwr = v[13], tb0 = v[14];
    bit own_bad = ns ? (own != 3) : (own != 1);
    int res; // 0 permit 1 undef 2 trap2 3 trap3
    if (el == 0) res = 1;
    else if (el == 3) res = 0;
    else if (hlt && e3 && lck && prio && own_bad) res = 1;
    else if (el == 1 && e2 && (!e3 || fen) && (wr ? fwr : frd)) res = 2;
    else if (el == 1 && e2 && !tb0) res = 2;
    else if (e3 && own_bad) res = (hlt && lck) ? 1 : 3;
    else res = 0;
    return {4'(1 << res), (res >= 2) ? 6'h18 : 6'h00};
  endfunction

  function automatic string tag(input int v);
    int el = v & 3;
    if (el == 0 || el == 3) return "R2";
    return "R8";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o}, 12'h0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R10", {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o}, 12'h0);

    // R3 R4 R5 R6 R7 R8 R9: exhaustive sweep of level, direction and control bits
    for (int v = 0; v < 32768; v++) begin
      el_i = 2'(v & 3); write_i = v[2]; halted_i = v[3]; dbg_lock_i = v[4];
      prio_opt_i = v[5]; nonsecure_i = v[6]; owner_i = 2'((v >> 7) & 3);
      el2_en_i = v[9]; el3_present_i = v[10]; fgt_en_i = v[11];
      fgt_rd_i = v[12]; fgt_wr_i = v[13]; tbtrap_i = {v[15], v[14]};
      req_valid_i = 1'b1;
      @(posedge clk); #1;
      req_valid_i = 1'b0;
      check(tag(v), {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o},
            {2'b10, model(v)});
    end

    // R10: idle cycle after a result
    @(posedge clk); #1;
    check("R10", {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o}, 12'h0);

    // R1: flip each encoding bit, both directions
    for (int b = 0; b < 16; b++) begin
      for (int w = 0; w < 2; w++) begin
        logic [15:0] enc;
        enc = {2'b11, 3'b000, 4'b1001, 4'b1011, 3'b110} ^ (16'h1 << b);
        {op0_i, op1_i, crn_i, crm_i, op2_i} = enc;
        write_i = w[0]; el_i = 2'd3;
        req_valid_i = 1'b1;
        @(posedge clk); #1;
        req_valid_i = 1'b0;
        check("R1", {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o}, 12'b11_0000_000000);
      end
    end
    {op0_i, op1_i, crn_i, crm_i, op2_i} = {2'b11, 3'b000, 4'b1001, 4'b1011, 3'b110};

    // R4: EL1 read ignores write trap bit and vice versa
    el_i = 2'd1; el2_en_i = 1; el3_present_i = 0; tbtrap_i = 2'b01;
    owner_i = 2'b01; nonsecure_i = 0; halted_i = 0;
    write_i = 0; fgt_rd_i = 0; fgt_wr_i = 1; req_valid_i = 1;
    @(posedge clk); #1; req_valid_i = 0;
    check("R4", {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o}, {2'b10, 4'b0001, 6'h00});
    write_i = 1; fgt_rd_i = 1; fgt_wr_i = 0; req_valid_i = 1;
    @(posedge clk); #1; req_valid_i = 0;
    check("R4", {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o}, {2'b10, 4'b0001, 6'h00});

    // R9: no result without a request
    @(posedge clk); #1;
    check("R9", {res_valid_o, res_nomatch_o, res_outcome_o, res_syndrome_o}, 12'h0);

    report();
  end
endmodule